// File: doc/BRIEF.md
# Serial Addressed Segment-Frame Loader

This block takes display frames from a three-wire serial port (select, data and shift clock) and keeps a 186-bit segment image for a 62-segment, three-common display. All three serial pins are sampled on the system clock. A low-to-high step of the shift clock, seen while select is high, pushes one data bit into a 72-stage shift register. A high-to-low step of select copies the register into the display image.

The image is split into three banks: segments 0–20, 21–41 and 42–61. The last three bits of every frame form a bank mask, so one frame can refresh one bank, several banks or none. A mode input picks how the frame is decoded. In three-common mode, three consecutive bits belong to one segment. In two-common mode, two consecutive bits belong to one segment and the frame is shorter. Decoding counts back from the newest bit, so a frame may leave out its leading bits for unused low segments.

Image bit `3*s + c` holds segment `s`, common `c`, where commons are numbered 0, 1 and 2.

Top module: `seg_frame_loader`

## Requirements
- R1: While reset is high at a clock edge, the shift register, the sampled pin history and the whole image are cleared to zero.
- R2: A clock edge at which select is sampled high, and the shift clock is sampled high after being low at the previous edge, shifts in one data bit. The newest bit sits in stage 71 and older bits move one stage toward stage 0. A shift clock that is already high when select rises does not shift.
- R3: Shift-clock steps sampled while select is low leave the register unchanged.
- R4: The image changes only at the clock edge where select is first sampled low after being high. A select pulse with no shift-clock steps still loads from the current register contents.
- R5: The address field works as follows:
  - Stage 69 (third-newest bit) enables bank 0, segments 0–20.
  - Stage 70 enables bank 1, segments 21–41.
  - Stage 71 (newest bit) enables bank 2, segments 42–61.
  - Any combination of these bits may be set, and every enabled bank loads from the same frame positions.
  - Banks that are not enabled keep their contents, so an all-zero field changes nothing.
- R6: In three-common mode (mode input high), local segment `j` of a bank takes common `c` from stage `3*j + c`. This is the layout of a 72-bit frame.
- R7: In two-common mode (mode input low), local segment `j` takes commons 0 and 1 from stages `24 + 2*j` and `24 + 2*j + 1`. This is the layout of a 48-bit frame. Common 2 of every loaded segment is written as 0.
- R8: Decoding is fixed to the newest stages. A frame that leaves out leading bits still places its remaining bits in the correct segments, and the stages it did not write hold older bits.
- R9: If the shift clock pauses for any number of cycles while select stays high, the partly received frame is kept and continues when clocking resumes.
- R10: The mode input is read at the clock edge of the load, not while the bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Serial select; data is accepted while high, and a fall loads the image |
| sck_i | input | 1 | Serial shift clock; a rising step shifts one bit in |
| dat_i | input | 1 | Serial data bit |
| duty3_i | input | 1 | Mode: 1 selects three-common decoding, 0 selects two-common decoding |
| disp_q | output | 186 | Segment image; bit `3*s+c` is segment `s`, common `c` |

## Verification
The bench drives frames that use each bank mask on its own, in pairs, all three together and all zero, in both modes. The checks target these faults:
- A design that reads the mask at the wrong stages, or with its bit order reversed, refreshes the wrong bank.
- A design that aligns decoding to the start of the frame shifts every segment of a 44-bit two-common frame by two places.
- Shift-clock steps while select is low, a select pulse with no bits, and a shift clock already high when select rises each expose a design that treats levels as edges or ignores the select gate.
- Loading before the mode has been switched shows whether the mode is read at load time.
- A design that leaves stale third-common bits in two-common mode fails the per-clock image comparison.

// File: rtl/segld_pkg.sv
`timescale 1ns/1ps
package segld_pkg;

    localparam int NUM_SEG  = 62;
    localparam int GRP_SEGS = 21;
    localparam int NUM_GRP  = 3;
    localparam int NUM_COM  = 3;
    localparam int FRAME_3C = 72;
    localparam int FRAME_2C = 48;
    localparam int SR_LEN   = (FRAME_3C > FRAME_2C) ? FRAME_3C : FRAME_2C;
    localparam int LAT_W    = NUM_SEG * NUM_COM;

    typedef enum logic {
        DUTY_2C = 1'b0,
        DUTY_3C = 1'b1
    } duty_e;

    typedef struct packed {
        logic cs;
        logic sck;
        logic dat;
    } ser_pins_t;

    typedef struct packed {
        logic shift;
        logic load;
        logic dat;
    } ser_evt_t;

    // number of segments carried by bank g
    function automatic int grp_seg_count(input int g, input int grp_segs, input int num_seg);
        int last;
        last = (g + 1) * grp_segs;
        if (last > num_seg) last = num_seg;
        return last - g * grp_segs;
    endfunction

    // first segment index of bank g
    function automatic int grp_first_seg(input int g, input int grp_segs);
        return g * grp_segs;
    endfunction

endpackage

// File: rtl/segld_shifter.sv
`timescale 1ns/1ps
module segld_shifter #(
    parameter int SR_LEN = segld_pkg::SR_LEN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  segld_pkg::ser_pins_t  pins,
    output logic [SR_LEN-1:0]     sr_q,
    output logic                  load_evt
);
    import segld_pkg::*;

    logic     sck_q;
    logic     cs_q;
    ser_evt_t evt;

    always_comb begin
        evt.shift = pins.cs & pins.sck & ~sck_q;
        evt.load  = cs_q & ~pins.cs;
        evt.dat   = pins.dat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b0;
            sr_q  <= '0;
        end else begin
            sck_q <= pins.sck;
            cs_q  <= pins.cs;
            if (evt.shift) begin
                sr_q <= {evt.dat, sr_q[SR_LEN-1:1]};
            end
        end
    end

    assign load_evt = evt.load;

    // R3
    gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        !pins.cs |=> $stable(sr_q));

    // R2
    newest_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (pins.cs && pins.sck && !sck_q) |=> (sr_q[SR_LEN-1] == $past(pins.dat)));

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (pins.cs && pins.sck && !sck_q) |=> (sr_q[SR_LEN-2:0] == $past(sr_q[SR_LEN-1:1])));

    // R9
    paused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(pins.sck && !sck_q) |=> $stable(sr_q));

endmodule

// File: rtl/segld_decode.sv
`timescale 1ns/1ps
module segld_decode #(
    parameter int NUM_SEG  = segld_pkg::NUM_SEG,
    parameter int GRP_SEGS = segld_pkg::GRP_SEGS,
    parameter int NUM_GRP  = segld_pkg::NUM_GRP,
    parameter int NUM_COM  = segld_pkg::NUM_COM,
    parameter int FRAME_3C = segld_pkg::FRAME_3C,
    parameter int FRAME_2C = segld_pkg::FRAME_2C,
    parameter int SR_LEN   = segld_pkg::SR_LEN,
    localparam int LAT_W   = NUM_SEG * NUM_COM
) (
    input  logic [SR_LEN-1:0]    sr_q,
    input  segld_pkg::duty_e     duty,
    output logic [NUM_GRP-1:0]   grp_sel,
    output logic [LAT_W-1:0]     image
);
    import segld_pkg::*;

    localparam int COM_2C  = NUM_COM - 1;
    localparam int BASE_3C = SR_LEN - FRAME_3C;
    localparam int BASE_2C = SR_LEN - FRAME_2C;
    localparam int ADDR_LO = SR_LEN - NUM_GRP;

    logic use_3c;
    assign use_3c = (duty == DUTY_3C);

    // bank mask: oldest of the newest NUM_GRP stages enables bank 0
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_addr
        assign grp_sel[g] = sr_q[ADDR_LO + g];
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam int J = s % GRP_SEGS;
        for (genvar c = 0; c < NUM_COM; c++) begin : g_com
            localparam int S3 = BASE_3C + NUM_COM * J + c;
            if (c < COM_2C) begin : g_both
                localparam int S2 = BASE_2C + COM_2C * J + c;
                assign image[s*NUM_COM + c] = use_3c ? sr_q[S3] : sr_q[S2];
            end else begin : g_only3
                assign image[s*NUM_COM + c] = use_3c & sr_q[S3];
            end
        end
    end

endmodule

// File: rtl/segld_bank_latch.sv
`timescale 1ns/1ps
module segld_bank_latch #(
    parameter int NUM_SEG  = segld_pkg::NUM_SEG,
    parameter int GRP_SEGS = segld_pkg::GRP_SEGS,
    parameter int NUM_GRP  = segld_pkg::NUM_GRP,
    parameter int NUM_COM  = segld_pkg::NUM_COM,
    localparam int LAT_W   = NUM_SEG * NUM_COM
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [NUM_GRP-1:0]  grp_sel,
    input  logic [LAT_W-1:0]    image,
    output logic [LAT_W-1:0]    disp_q
);
    import segld_pkg::*;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
        localparam int FIRST = grp_first_seg(g, GRP_SEGS) * NUM_COM;
        localparam int W     = grp_seg_count(g, GRP_SEGS, NUM_SEG) * NUM_COM;

        logic [W-1:0] bank_q;
        logic         we;

        assign we = load & grp_sel[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= '0;
            end else if (we) begin
                bank_q <= image[FIRST +: W];
            end
        end

        assign disp_q[FIRST +: W] = bank_q;

        // R5
        bank_keep_chk: assert property (@(posedge clk) disable iff (rst)
            !(load && grp_sel[g]) |=> $stable(disp_q[FIRST +: W]));

        // R4
        bank_take_chk: assert property (@(posedge clk) disable iff (rst)
            (load && grp_sel[g]) |=> (disp_q[FIRST +: W] == $past(image[FIRST +: W])));
    end

endmodule

// File: rtl/seg_frame_loader.sv
`timescale 1ns/1ps
module seg_frame_loader #(
    parameter int NUM_SEG  = segld_pkg::NUM_SEG,
    parameter int GRP_SEGS = segld_pkg::GRP_SEGS,
    parameter int NUM_GRP  = segld_pkg::NUM_GRP,
    parameter int NUM_COM  = segld_pkg::NUM_COM,
    parameter int FRAME_3C = segld_pkg::FRAME_3C,
    parameter int FRAME_2C = segld_pkg::FRAME_2C,
    localparam int SR_LEN  = (FRAME_3C > FRAME_2C) ? FRAME_3C : FRAME_2C,
    localparam int LAT_W   = NUM_SEG * NUM_COM
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_i,
    input  logic             sck_i,
    input  logic             dat_i,
    input  logic             duty3_i,
    output logic [LAT_W-1:0] disp_q
);
    import segld_pkg::*;

    ser_pins_t           pins;
    duty_e               duty;
    logic [SR_LEN-1:0]   sr_q;
    logic                load_evt;
    logic [NUM_GRP-1:0]  grp_sel;
    logic [LAT_W-1:0]    image;

    always_comb begin
        pins.cs  = cs_i;
        pins.sck = sck_i;
        pins.dat = dat_i;
        duty     = duty3_i ? DUTY_3C : DUTY_2C;
    end

    segld_shifter #(
        .SR_LEN (SR_LEN)
    ) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .pins     (pins),
        .sr_q     (sr_q),
        .load_evt (load_evt)
    );

    segld_decode #(
        .NUM_SEG  (NUM_SEG),
        .GRP_SEGS (GRP_SEGS),
        .NUM_GRP  (NUM_GRP),
        .NUM_COM  (NUM_COM),
        .FRAME_3C (FRAME_3C),
        .FRAME_2C (FRAME_2C),
        .SR_LEN   (SR_LEN)
    ) u_decode (
        .sr_q    (sr_q),
        .duty    (duty),
        .grp_sel (grp_sel),
        .image   (image)
    );

    segld_bank_latch #(
        .NUM_SEG  (NUM_SEG),
        .GRP_SEGS (GRP_SEGS),
        .NUM_GRP  (NUM_GRP),
        .NUM_COM  (NUM_COM)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (load_evt),
        .grp_sel (grp_sel),
        .image   (image),
        .disp_q  (disp_q)
    );

    // R4
    image_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load_evt |=> $stable(disp_q));

    // R5
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (load_evt && (grp_sel == '0)) |=> $stable(disp_q));

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_c3
        // R7
        third_com_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (load_evt && grp_sel[s / GRP_SEGS] && !duty3_i)
                |=> !disp_q[s*NUM_COM + NUM_COM - 1]);
    end

endmodule

// File: tb/seg_frame_loader_bench.sv
`timescale 1ns/1ps
module seg_frame_loader_bench;
    import segld_pkg::*;

    localparam int W = NUM_SEG * NUM_COM;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0;
    logic sck = 1'b0;
    logic dat = 1'b0;
    logic duty3 = 1'b0;
    logic [W-1:0] disp;

    seg_frame_loader u_seg_frame_loader (
        .clk     (clk),
        .rst     (rst),
        .cs_i    (cs),
        .sck_i   (sck),
        .dat_i   (dat),
        .duty3_i (duty3),
        .disp_q  (disp)
    );

    always #2 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    bit sr_m[$];
    bit lat_m[W];
    bit pcs = 1'b0;
    bit psck = 1'b0;
    bit fr[$];
    logic [W-1:0] saved;

    task automatic model_load();
        for (int g = 0; g < NUM_GRP; g++) begin
            if (sr_m[SR_LEN - NUM_GRP + g]) begin
                for (int s = g * GRP_SEGS; s < NUM_SEG && s < (g + 1) * GRP_SEGS; s++) begin
                    int j = s - g * GRP_SEGS;
                    for (int c = 0; c < NUM_COM; c++) begin
                        bit v;
                        if (duty3) v = sr_m[SR_LEN - FRAME_3C + 3 * j + c];
                        else if (c < 2) v = sr_m[SR_LEN - FRAME_2C + 2 * j + c];
                        else v = 1'b0;
                        lat_m[s * NUM_COM + c] = v;
                    end
                end
            end
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            sr_m.delete();
            for (int i = 0; i < SR_LEN; i++) sr_m.push_back(1'b0);
            for (int i = 0; i < W; i++) lat_m[i] = 1'b0;
            pcs = 1'b0;
            psck = 1'b0;
        end else begin
            if (pcs && !cs) begin
                model_load();
            end else if (cs && sck && !psck) begin
                sr_m.push_back(dat);
                void'(sr_m.pop_front());
            end
            pcs = cs;
            psck = sck;
        end
    endtask

    task automatic compare();
        logic [W-1:0] exp_v;
        for (int i = 0; i < W; i++) exp_v[i] = lat_m[i];
        n_cmp++;
        if (disp !== exp_v) begin
            n_bad++;
            $display("FAIL %s: image actual=%h expected=%h", cur_req, disp, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic check_bit(input int idx, input bit want, input string req);
        n_cmp++;
        if (disp[idx] !== want) begin
            n_bad++;
            $display("FAIL %s: image bit %0d actual=%b expected=%b", req, idx, disp[idx], want);
        end
    endtask

    task automatic build(input int len, input bit [2:0] addr, input int seed);
        fr.delete();
        for (int i = 0; i < len - 3; i++) fr.push_back(((i * 13 + seed * 7) % 5) < 2);
        fr.push_back(addr[0]);
        fr.push_back(addr[1]);
        fr.push_back(addr[2]);
    endtask

    task automatic send_bit(input bit b);
        cs = 1'b1;
        sck = 1'b0;
        dat = b;
        step();
        sck = 1'b1;
        step();
    endtask

    task automatic send_frame();
        foreach (fr[i]) send_bit(fr[i]);
        sck = 1'b0;
        step();
        cs = 1'b0;
        step();
        step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        check_bit(0, 1'b0, "R1");
        check_bit(W - 1, 1'b0, "R1");

        // R6 three-common, bank 0
        cur_req = "R6";
        duty3 = 1'b1;
        build(FRAME_3C, 3'b001, 1);
        send_frame();
        check_bit(0, fr[0], "R6");
        check_bit(17, fr[17], "R6");

        // R6 three-common, bank 2 (20 segments)
        build(FRAME_3C, 3'b100, 2);
        send_frame();
        check_bit(W - 1, fr[59], "R6");
        check_bit(42 * 3, fr[0], "R6");

        // R7 two-common, bank 1; third common cleared
        cur_req = "R7";
        duty3 = 1'b0;
        build(FRAME_2C, 3'b010, 3);
        send_frame();
        check_bit(64, fr[1], "R7");
        check_bit(65, 1'b0, "R7");

        // R5 two banks from one frame
        cur_req = "R5";
        build(FRAME_2C, 3'b011, 4);
        send_frame();
        check_bit(0, fr[0], "R5");
        check_bit(63, fr[0], "R5");

        // R5 all-zero mask changes nothing
        saved = disp;
        duty3 = 1'b1;
        build(FRAME_3C, 3'b000, 9);
        send_frame();
        n_cmp++;
        if (disp !== saved) begin
            n_bad++;
            $display("FAIL R5: zero mask image actual=%h expected=%h", disp, saved);
        end

        // R5 all three banks
        build(FRAME_3C, 3'b111, 6);
        send_frame();
        check_bit(21 * 3 + 2, fr[2], "R5");

        // R8 short two-common frame (44 bits), bank 0
        cur_req = "R8";
        duty3 = 1'b0;
        build(FRAME_2C - 4, 3'b001, 5);
        send_frame();
        check_bit(6, fr[0], "R8");
        check_bit(7, fr[1], "R8");

        // R3 shift-clock steps while select low are ignored, then empty select pulse
        cur_req = "R3";
        dat = 1'b1;
        for (int k = 0; k < 10; k++) begin
            sck = ~sck;
            step();
        end
        sck = 1'b0;
        step();
        saved = disp;
        cur_req = "R4";
        cs = 1'b1;
        step();
        cs = 1'b0;
        step();
        step();
        n_cmp++;
        if (disp !== saved) begin
            n_bad++;
            $display("FAIL R3: image after ignored clocks actual=%h expected=%h", disp, saved);
        end

        // R10 mode read at load: same register, switch to three-common, empty pulse
        cur_req = "R10";
        duty3 = 1'b1;
        step();
        cs = 1'b1;
        step();
        cs = 1'b0;
        step();
        step();

        // R2 shift clock already high when select rises does not shift
        cur_req = "R2";
        sck = 1'b1;
        dat = 1'b0;
        step();
        cs = 1'b1;
        step();
        step();
        sck = 1'b0;
        step();
        cs = 1'b0;
        step();
        step();

        // R9 pause mid-frame
        cur_req = "R9";
        duty3 = 1'b1;
        build(FRAME_3C, 3'b101, 8);
        for (int i = 0; i < 30; i++) send_bit(fr[i]);
        sck = 1'b0;
        repeat (50) step();
        for (int i = 30; i < FRAME_3C; i++) send_bit(fr[i]);
        sck = 1'b0;
        step();
        cs = 1'b0;
        step();
        step();
        check_bit(5, fr[5], "R9");
        check_bit(50 * 3 + 1, fr[3 * 8 + 1], "R9");

        // R1 reset again clears image
        cur_req = "R1";
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        check_bit(5, 1'b0, "R1");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule